// File: doc/BRIEF.md
# NAND Page ECC Interposer

This block sits on the byte-wide path between a flash command sequencer and a NAND device. It protects each 512-byte data block with a Hamming-style code. When protection is switched off, every control strobe and data byte passes through combinationally, with no added cycle. When it is on, the block still passes the sequencer's traffic unchanged. It also folds each data byte into a running line and column parity code, using the byte's value and its index in the block.

When a 512-byte program transfer ends, the block takes the flash bus for twelve cycles and writes its twelve check bytes into the spare area. When a 512-byte read ends, it takes twelve read cycles to fetch the stored check bytes. It then XORs the stored and computed codes and reports one result: clean, a correctable single data-bit error (with the byte index and a one-hot bit mask to XOR into that byte), an error confined to the check bytes, or an uncorrectable error. The sequencer is expected to issue nothing while the block holds the bus, because that time falls in the gap before its next command.

Top module: `nand_ecc_tap`

## Requirements
- R1: With `ecc_en` low, the outputs `fl_cle`, `fl_ale`, `fl_wr_stb`, `fl_rd_stb` and `fl_dout` equal the matching upstream inputs in the same cycle. No check bytes are inserted, and `blk_done` and `res_valid` stay low.
- R2: With `ecc_en` high and no insertion in progress, upstream strobes and data reach the flash unchanged, and `us_rdata` always equals `fl_din`.
- R3: The code has twelve bytes. Code bit k (0..8) is the XOR of the parities of all bytes whose 9-bit index has bit k clear. Bit 24+k covers the bytes whose index has bit k set. Bit 48+j (j = 0..2) is the XOR of every data bit whose 3-bit bit position has bit j clear, and bit 72+j covers the data bits where it is set. All other code bits are 0. Check byte n holds code bits 8n+7..8n.
- R4: A data byte is a cycle with a strobe and with `us_cle` and `us_ale` low. `blk_done` pulses for exactly one cycle, in the cycle after the 512th data byte of a block.
- R5: After a 512-byte program block, `fl_wr_stb` is high for the next twelve cycles with `fl_cle` and `fl_ale` low. `fl_dout` carries check bytes 0 to 11 in order.
- R6: After a 512-byte read block, `fl_rd_stb` is high for the next twelve cycles and `fl_din` is taken as stored check bytes 0 to 11. `res_valid` is high for one cycle, the 13th cycle after the last data byte.
- R7: If the stored and computed codes match, `res_kind` = 0 and `fix_mask` = 0.
- R8: If a single data bit differs, `res_kind` = 1. `fix_addr` gives the byte index and `fix_mask` has a one only at that bit's position.
- R9: If a single stored check bit differs (unused bits included), `res_kind` = 2 and `fix_mask` = 0.
- R10: Any other mismatch, such as two flipped data bits, gives `res_kind` = 3 and `fix_mask` = 0.
- R11: A cycle with `us_cle` or `us_ale` high restarts the byte count, so a partial block produces no `blk_done`.
- R12: Driving `ecc_en` low for a cycle abandons the block in progress, and counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Enables code generation and checking |
| us_cle | input | 1 | Command latch from sequencer |
| us_ale | input | 1 | Address latch from sequencer |
| us_wr_stb | input | 1 | Write strobe from sequencer |
| us_rd_stb | input | 1 | Read strobe from sequencer |
| us_wdata | input | 8 | Write byte from sequencer |
| us_rdata | output | 8 | Read byte returned to sequencer |
| fl_cle | output | 1 | Command latch to flash |
| fl_ale | output | 1 | Address latch to flash |
| fl_wr_stb | output | 1 | Write strobe to flash |
| fl_rd_stb | output | 1 | Read strobe to flash |
| fl_dout | output | 8 | Write byte to flash |
| fl_din | input | 8 | Read byte from flash |
| blk_done | output | 1 | One-cycle pulse after the 512th byte |
| res_valid | output | 1 | Check result strobe |
| res_kind | output | 2 | 0 clean, 1 fixed, 2 code-only, 3 uncorrectable |
| fix_addr | output | 9 | Byte index of the corrected byte |
| fix_mask | output | 8 | One-hot XOR mask for the corrected byte |

## Verification
The assertions check on every cycle that bypass mirrors the upstream pins, that inserted writes never assert a latch, that `blk_done` only follows a strobe, that a result appears only after a fetch cycle, and that the fix mask is one-hot exactly when a fix is reported. The value of the check bytes, where the single-bit error is located, and how the four result classes are told apart can only be shown by the bench's scenarios. In those, each page is programmed into a flash model, corrupted at chosen bit positions, read back, and compared with a code computed bit by bit.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int DATA_W     = 8;
    localparam int BIT_W      = 3;
    localparam int GRP_W      = 24;
    localparam int NUM_GRP    = 4;
    localparam int CODE_W     = GRP_W * NUM_GRP;
    localparam int CODE_BYTES = CODE_W / DATA_W;

    // Field order: line_even sits at the least significant end (bytes 0..2).
    typedef struct packed {
        logic [GRP_W-1:0] col_odd;
        logic [GRP_W-1:0] col_even;
        logic [GRP_W-1:0] line_odd;
        logic [GRP_W-1:0] line_even;
    } grp_code_t;

    typedef enum logic [1:0] {
        RES_CLEAN = 2'd0,
        RES_FIXED = 2'd1,
        RES_CODE  = 2'd2,
        RES_FAIL  = 2'd3
    } res_kind_e;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_PUT  = 2'd1,
        ST_GET  = 2'd2,
        ST_EVAL = 2'd3
    } tap_state_e;

    // XOR of the data bits whose position has bit j equal to sel.
    function automatic logic col_par(input logic [DATA_W-1:0] d,
                                     input int j, input logic sel);
        logic acc;
        acc = 1'b0;
        for (int b = 0; b < DATA_W; b++) begin
            if (((b >> j) & 1) == int'(sel))
                acc = acc ^ d[b];
        end
        return acc;
    endfunction

endpackage

// File: rtl/ecc_accum.sv
module ecc_accum
    import nand_ecc_pkg::*;
#(
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic              first,
    input  logic [LINE_W-1:0] idx,
    input  logic [DATA_W-1:0] d,
    output grp_code_t         code
);

    grp_code_t code_q;
    grp_code_t code_n;

    always_comb begin
        logic p;
        code_n = first ? '0 : code_q;
        p = ^d;
        for (int k = 0; k < LINE_W; k++) begin
            if (idx[k]) code_n.line_odd[k]  = code_n.line_odd[k]  ^ p;
            else        code_n.line_even[k] = code_n.line_even[k] ^ p;
        end
        for (int j = 0; j < BIT_W; j++) begin
            code_n.col_odd[j]  = code_n.col_odd[j]  ^ col_par(d, j, 1'b1);
            code_n.col_even[j] = code_n.col_even[j] ^ col_par(d, j, 1'b0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      code_q <= '0;
        else if (upd) code_q <= code_n;
    end

    assign code = code_q;

endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
    import nand_ecc_pkg::*;
#(
    parameter int LINE_W = 9
) (
    input  grp_code_t         stored,
    input  grp_code_t         calc,
    output res_kind_e         kind,
    output logic [LINE_W-1:0] addr,
    output logic [DATA_W-1:0] mask
);

    localparam logic [GRP_W-1:0] LMASK = GRP_W'((1 << LINE_W) - 1);
    localparam logic [GRP_W-1:0] CMASK = GRP_W'((1 << BIT_W) - 1);

    grp_code_t         syn;
    logic [LINE_W-1:0] line_x;
    logic [BIT_W-1:0]  col_x;
    logic              spare_zero;
    logic              single;

    always_comb begin
        syn        = stored ^ calc;
        line_x     = syn.line_odd[LINE_W-1:0] ^ syn.line_even[LINE_W-1:0];
        col_x      = syn.col_odd[BIT_W-1:0] ^ syn.col_even[BIT_W-1:0];
        spare_zero = ((syn.line_odd & ~LMASK) == '0) && ((syn.line_even & ~LMASK) == '0)
                  && ((syn.col_odd & ~CMASK) == '0) && ((syn.col_even & ~CMASK) == '0);
        single     = (&line_x) && (&col_x) && spare_zero;

        if (syn == '0)                   kind = RES_CLEAN;
        else if (single)                 kind = RES_FIXED;
        else if ($countones(syn) == 1)   kind = RES_CODE;
        else                             kind = RES_FAIL;

        addr = syn.line_odd[LINE_W-1:0];
        mask = DATA_W'(1) << syn.col_odd[BIT_W-1:0];
    end

endmodule

// File: rtl/ecc_seq.sv
module ecc_seq
    import nand_ecc_pkg::*;
#(
    parameter int BLK_BYTES = 512,
    localparam int IDX_W    = $clog2(BLK_BYTES),
    localparam int CHK_W    = $clog2(CODE_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ecc_en,
    input  logic             us_cle,
    input  logic             us_ale,
    input  logic             us_wr_stb,
    input  logic             us_rd_stb,
    output logic             upd,
    output logic             first,
    output logic [IDX_W-1:0] idx,
    output tap_state_e       state,
    output logic [CHK_W-1:0] chk_idx,
    output logic             blk_done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_BYTES - 1);
    localparam logic [CHK_W-1:0] LAST_CHK = CHK_W'(CODE_BYTES - 1);

    tap_state_e       state_q;
    logic [IDX_W-1:0] cnt_q;
    logic [CHK_W-1:0] chk_q;
    logic             done_q;
    logic             data_stb;
    logic             last;

    assign data_stb = ecc_en && (state_q == ST_PASS) && !us_cle && !us_ale
                   && (us_wr_stb || us_rd_stb);
    assign last     = data_stb && (cnt_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst || !ecc_en) begin
            state_q <= ST_PASS;
            cnt_q   <= '0;
            chk_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last;
            case (state_q)
                ST_PASS: begin
                    if (us_cle || us_ale) begin
                        cnt_q <= '0;
                    end else if (last) begin
                        cnt_q   <= '0;
                        chk_q   <= '0;
                        state_q <= us_wr_stb ? ST_PUT : ST_GET;
                    end else if (data_stb) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_PUT, ST_GET: begin
                    chk_q <= chk_q + 1'b1;
                    if (chk_q == LAST_CHK)
                        state_q <= (state_q == ST_PUT) ? ST_PASS : ST_EVAL;
                end
                default: state_q <= ST_PASS;
            endcase
        end
    end

    assign upd      = data_stb;
    assign first    = (cnt_q == '0);
    assign idx      = cnt_q;
    assign state    = state_q;
    assign chk_idx  = chk_q;
    assign blk_done = done_q;

endmodule

// File: rtl/nand_ecc_tap.sv
module nand_ecc_tap
    import nand_ecc_pkg::*;
#(
    parameter int BLK_BYTES = 512,
    localparam int LINE_W   = $clog2(BLK_BYTES),
    localparam int CHK_W    = $clog2(CODE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ecc_en,
    input  logic              us_cle,
    input  logic              us_ale,
    input  logic              us_wr_stb,
    input  logic              us_rd_stb,
    input  logic [7:0]        us_wdata,
    output logic [7:0]        us_rdata,
    output logic              fl_cle,
    output logic              fl_ale,
    output logic              fl_wr_stb,
    output logic              fl_rd_stb,
    output logic [7:0]        fl_dout,
    input  logic [7:0]        fl_din,
    output logic              blk_done,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic [LINE_W-1:0] fix_addr,
    output logic [7:0]        fix_mask
);

    tap_state_e        state;
    logic [CHK_W-1:0]  chk_idx;
    logic              upd;
    logic              first;
    logic [LINE_W-1:0] idx;
    grp_code_t         calc;
    grp_code_t         stored_q;
    logic [CODE_W-1:0] calc_vec;
    res_kind_e         kind;
    logic [LINE_W-1:0] c_addr;
    logic [DATA_W-1:0] c_mask;
    logic              ins_put;
    logic              ins_get;

    ecc_seq #(.BLK_BYTES(BLK_BYTES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ecc_en   (ecc_en),
        .us_cle   (us_cle),
        .us_ale   (us_ale),
        .us_wr_stb(us_wr_stb),
        .us_rd_stb(us_rd_stb),
        .upd      (upd),
        .first    (first),
        .idx      (idx),
        .state    (state),
        .chk_idx  (chk_idx),
        .blk_done (blk_done)
    );

    ecc_accum #(.LINE_W(LINE_W)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .upd  (upd),
        .first(first),
        .idx  (idx),
        .d    (us_wr_stb ? us_wdata : fl_din),
        .code (calc)
    );

    ecc_classify #(.LINE_W(LINE_W)) u_cls (
        .stored(stored_q),
        .calc  (calc),
        .kind  (kind),
        .addr  (c_addr),
        .mask  (c_mask)
    );

    assign calc_vec = calc;
    assign ins_put  = (state == ST_PUT);
    assign ins_get  = (state == ST_GET);

    always_ff @(posedge clk) begin
        if (rst)
            stored_q <= '0;
        else if (ins_get)
            stored_q[{chk_idx, 3'b000} +: DATA_W] <= fl_din;
    end

    always_comb begin
        if (ins_put || ins_get) begin
            fl_cle    = 1'b0;
            fl_ale    = 1'b0;
            fl_wr_stb = ins_put;
            fl_rd_stb = ins_get;
            fl_dout   = ins_put ? calc_vec[{chk_idx, 3'b000} +: DATA_W] : us_wdata;
        end else begin
            fl_cle    = us_cle;
            fl_ale    = us_ale;
            fl_wr_stb = us_wr_stb;
            fl_rd_stb = us_rd_stb;
            fl_dout   = us_wdata;
        end
    end

    assign us_rdata  = fl_din;
    assign res_valid = (state == ST_EVAL);
    assign res_kind  = res_valid ? kind : RES_CLEAN;
    assign fix_addr  = (res_valid && kind == RES_FIXED) ? c_addr : '0;
    assign fix_mask  = (res_valid && kind == RES_FIXED) ? c_mask : '0;

endmodule

// File: rtl/nand_ecc_tap_chk.sv
module nand_ecc_tap_chk (
    input logic       clk,
    input logic       rst,
    input logic       ecc_en,
    input logic       us_cle,
    input logic       us_ale,
    input logic       us_wr_stb,
    input logic       us_rd_stb,
    input logic [7:0] us_wdata,
    input logic       fl_cle,
    input logic       fl_ale,
    input logic       fl_wr_stb,
    input logic       fl_rd_stb,
    input logic [7:0] fl_dout,
    input logic       blk_done,
    input logic       res_valid,
    input logic [1:0] res_kind,
    input logic [7:0] fix_mask
);

    // R1
    bypass_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        !ecc_en |-> (fl_cle == us_cle && fl_ale == us_ale && fl_wr_stb == us_wr_stb
                     && fl_rd_stb == us_rd_stb && fl_dout == us_wdata));

    // R1
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ecc_en |=> (!blk_done && !res_valid));

    // R4
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        blk_done |-> $past(us_wr_stb || us_rd_stb));

    // R5
    insert_no_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_wr_stb && !us_wr_stb) |-> (!fl_cle && !fl_ale));

    // R6
    result_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(fl_rd_stb));

    // R8
    fix_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == 2'd1) |-> ($countones(fix_mask) == 1));

    // R9
    no_fix_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && res_kind == 2'd1) |-> (fix_mask == 8'd0));

endmodule

bind nand_ecc_tap nand_ecc_tap_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ecc_en   (ecc_en),
    .us_cle   (us_cle),
    .us_ale   (us_ale),
    .us_wr_stb(us_wr_stb),
    .us_rd_stb(us_rd_stb),
    .us_wdata (us_wdata),
    .fl_cle   (fl_cle),
    .fl_ale   (fl_ale),
    .fl_wr_stb(fl_wr_stb),
    .fl_rd_stb(fl_rd_stb),
    .fl_dout  (fl_dout),
    .blk_done (blk_done),
    .res_valid(res_valid),
    .res_kind (res_kind),
    .fix_mask (fix_mask)
);

// File: tb/sim_nand_ecc_tap.sv
`timescale 1ns/1ps
module sim_nand_ecc_tap;

    localparam int NB   = 512;
    localparam int NMEM = NB + 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ecc_en = 1'b0;
    logic       us_cle = 1'b0, us_ale = 1'b0, us_wr_stb = 1'b0, us_rd_stb = 1'b0;
    logic [7:0] us_wdata = 8'd0;
    logic [7:0] us_rdata;
    logic       fl_cle, fl_ale, fl_wr_stb, fl_rd_stb;
    logic [7:0] fl_dout, fl_din;
    logic       blk_done, res_valid;
    logic [1:0] res_kind;
    logic [8:0] fix_addr;
    logic [7:0] fix_mask;

    int checks = 0;
    int fails  = 0;
    int done_seen = 0;
    int wr_seen   = 0;

    logic [7:0] fmem [NMEM];
    logic [7:0] dat  [NB];
    int wptr = 0, rptr = 0;

    always #4 clk = ~clk;

    nand_ecc_tap u0 (.*);

    assign fl_din = (rptr < NMEM) ? fmem[rptr] : 8'hFF;

    // flash model: latches reset the pointers
    always @(posedge clk) begin
        if (fl_cle) begin
            wptr <= 0;
            rptr <= 0;
        end else begin
            if (fl_wr_stb && wptr < NMEM) begin
                fmem[wptr] <= fl_dout;
                wptr <= wptr + 1;
            end
            if (fl_rd_stb) rptr <= rptr + 1;
        end
    end

    always @(negedge clk) begin
        if (blk_done)  done_seen++;
        if (fl_wr_stb) wr_seen++;
    end

    // {seed, flips, pos1, pos2, kind}; pos = byte*8 + bit, bytes 512.. are check bytes
    localparam logic [37:0] VEC [8] = '{
        {8'd3,  2'd0, 13'd0,    13'd0,    2'd0},
        {8'd5,  2'd1, 13'd0,    13'd0,    2'd1},
        {8'd9,  2'd1, 13'd4095, 13'd0,    2'd1},
        {8'd17, 2'd1, 13'd2402, 13'd0,    2'd1},
        {8'd33, 2'd1, 13'd4099, 13'd0,    2'd2},
        {8'd65, 2'd2, 13'd81,   13'd1605, 2'd3},
        {8'd77, 2'd2, 13'd320,  13'd321,  2'd3},
        {8'd99, 2'd1, 13'd4119, 13'd0,    2'd2}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        us_cle = 1'b0; us_ale = 1'b0; us_wr_stb = 1'b0; us_rd_stb = 1'b0;
    endtask

    task automatic cmd_pulse();
        @(negedge clk);
        us_cle = 1'b1; us_ale = 1'b0; us_wr_stb = 1'b1; us_rd_stb = 1'b0; us_wdata = 8'h80;
        idle_cycle();
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        us_cle = 1'b0; us_ale = 1'b0; us_wr_stb = 1'b1; us_rd_stb = 1'b0; us_wdata = b;
    endtask

    function automatic logic [95:0] ref_code();
        logic [95:0] c;
        c = '0;
        for (int i = 0; i < NB; i++)
            for (int b = 0; b < 8; b++)
                if (dat[i][b]) begin
                    for (int k = 0; k < 9; k++)
                        if ((i >> k) & 1) c[24 + k] = ~c[24 + k];
                        else              c[k]      = ~c[k];
                    for (int j = 0; j < 3; j++)
                        if ((b >> j) & 1) c[72 + j] = ~c[72 + j];
                        else              c[48 + j] = ~c[48 + j];
                end
        return c;
    endfunction

    initial begin
        #(8.0 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [95:0] exp_code;
        logic [95:0] got_code;
        int n, bad;

        for (int i = 0; i < NMEM; i++) fmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!blk_done && !res_valid && fix_mask == 0 && !fl_wr_stb, "reset",
              {blk_done, res_valid}, 0);

        // R1: bypass mirrors the upstream pins
        @(negedge clk);
        us_cle = 1'b1; us_ale = 1'b1; us_wr_stb = 1'b1; us_rd_stb = 1'b1; us_wdata = 8'hA5;
        #1;
        check(fl_cle && fl_ale && fl_wr_stb && fl_rd_stb && fl_dout == 8'hA5, "R1 mirror",
              fl_dout, 8'hA5);
        cmd_pulse();
        done_seen = 0; wr_seen = 0;
        for (int i = 0; i < NB; i++) put_byte(8'(i));
        repeat (16) idle_cycle();
        check(done_seen == 0 && wr_seen == NB, "R1 no insert", wr_seen, NB);

        // table of program / corrupt / read cases
        ecc_en = 1'b1;
        for (int v = 0; v < 8; v++) begin
            logic [7:0]  seed;
            logic [1:0]  nfl;
            logic [12:0] p1, p2;
            logic [1:0]  ek;
            {seed, nfl, p1, p2, ek} = VEC[v];
            for (int i = 0; i < NB; i++) dat[i] = 8'(i * seed) ^ 8'(i >> 3) ^ seed;
            exp_code = ref_code();

            cmd_pulse();
            for (int i = 0; i < NB; i++) begin
                put_byte(dat[i]);
                if (i == NB - 1) begin
                    #1;
                    check(!blk_done, "R4 early", blk_done, 0);
                end
            end
            idle_cycle();
            #1;
            check(blk_done == 1'b1, "R4 done pulse", blk_done, 1);
            check(fl_wr_stb && !fl_cle && !fl_ale && fl_dout == exp_code[7:0], "R5 first check byte",
                  fl_dout, exp_code[7:0]);
            idle_cycle();
            #1;
            check(!blk_done, "R4 pulse width", blk_done, 0);
            repeat (14) idle_cycle();
            for (int i = 0; i < 12; i++) got_code[8*i +: 8] = fmem[NB + i];
            check(got_code == exp_code, "R3 R5 check bytes", 0, 0);
            if (got_code != exp_code) $display("  code got=%h exp=%h", got_code, exp_code);
            bad = 0;
            for (int i = 0; i < NB; i++) if (fmem[i] != dat[i]) bad++;
            check(bad == 0, "R2 data pass", bad, 0);

            if (nfl >= 1) fmem[p1 >> 3][p1[2:0]] = ~fmem[p1 >> 3][p1[2:0]];
            if (nfl == 2) fmem[p2 >> 3][p2[2:0]] = ~fmem[p2 >> 3][p2[2:0]];

            cmd_pulse();
            bad = 0;
            for (int i = 0; i < NB; i++) begin
                @(negedge clk);
                us_rd_stb = 1'b1; us_wr_stb = 1'b0;
                #1;
                if (us_rdata !== fmem[i] || !fl_rd_stb) bad++;
            end
            check(bad == 0, "R2 read pass", bad, 0);
            n = 0;
            do begin
                idle_cycle();
                n++;
                #1;
            end while (!res_valid && n < 30);
            check(n == 13, "R6 result timing", n, 13);
            case (ek)
                2'd0: check(res_kind == 2'd0 && fix_mask == 0, "R7 clean", res_kind, 0);
                2'd1: begin
                    check(res_kind == 2'd1, "R8 kind", res_kind, 1);
                    check(fix_addr == 9'(p1 >> 3), "R8 addr", fix_addr, p1 >> 3);
                    check(fix_mask == 8'(1 << p1[2:0]), "R8 mask", fix_mask, 1 << p1[2:0]);
                end
                2'd2: check(res_kind == 2'd2 && fix_mask == 0, "R9 code error", res_kind, 2);
                default: check(res_kind == 2'd3 && fix_mask == 0, "R10 uncorrectable", res_kind, 3);
            endcase
            idle_cycle();
            #1;
            check(!res_valid, "R6 single cycle", res_valid, 0);
        end

        // R11: latch cycle restarts the count
        cmd_pulse();
        done_seen = 0;
        for (int i = 0; i < 100; i++) put_byte(8'h11);
        cmd_pulse();
        for (int i = 0; i < NB - 1; i++) put_byte(8'h22);
        idle_cycle();
        check(done_seen == 0, "R11 partial", done_seen, 0);
        put_byte(8'h33);
        repeat (16) idle_cycle();
        check(done_seen == 1, "R11 restart", done_seen, 1);

        // R12: dropping enable abandons the block
        cmd_pulse();
        done_seen = 0;
        for (int i = 0; i < 300; i++) put_byte(8'h44);
        idle_cycle();
        ecc_en = 1'b0;
        idle_cycle();
        ecc_en = 1'b1;
        for (int i = 0; i < 212; i++) put_byte(8'h55);
        repeat (16) idle_cycle();
        check(done_seen == 0, "R12 abandon", done_seen, 0);
        for (int i = 0; i < 300; i++) put_byte(8'h66);
        repeat (16) idle_cycle();
        check(done_seen == 1, "R12 recount", done_seen, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule